// File: doc/BRIEF.md
# Overcurrent Alert and Status Controller

This block watches current-channel samples from an ADC and an external overcurrent-timer flag, and keeps two sticky status bits: one for ADC over-threshold events and one for timed overcurrent events. It drives an active-low alert pin whenever a status bit is set. Three small registers control it: an enable register, an 8-bit threshold, and a control register with a software-off bit. A plain write port loads these registers, and their contents are always visible on readback outputs.

Samples arrive on a valid/ready stream. `smp_ready` is low while reset is held and stays high at all other times, so the block never applies back-pressure. A sample is taken only on a cycle where `smp_valid` and `smp_ready` are both high. A sample offered while `smp_ready` is low, or with `smp_valid` low, has no effect.

An ADC event can be raised either by a single sample above the threshold or by an unbroken run of such samples. Clearing is done through a self-clearing bit in the enable register.

Top module: `ocp_alert_ctrl`

## Requirements
- R1: After reset, the enable readback is 0x04, the threshold readback is 0xFF, the control readback is 0x00, both status bits are 0, `alert_n` is 1 and `smp_ready` is 1.
- R2: A write with index 1 loads the enable register from data bits 4:0, and its upper readback bits read 0. Index 2 loads the threshold. Index 3 loads the software-off bit from data bit 0. A write with index 0 changes nothing.
- R3: A sample exceeds the threshold only when its upper 8 bits (bits 11:4) are strictly greater than the threshold. With the threshold at 0xFF, no sample can raise an ADC event.
- R4: With enable bit 0 set, a taken sample that exceeds the threshold sets `stat_adc` on the same clock edge.
- R5: With enable bit 1 set, `stat_adc` is set on the fourth consecutive taken sample that exceeds the threshold. A taken sample that does not exceed resets the run. Cycles without a taken sample leave the run unchanged. The run count saturates, so each further exceeding sample sets the bit again.
- R6: With enable bit 2 set, `stat_oc` is set when `oc_active` and `tmr_expired` are both high. Neither input alone sets it, and nothing sets it while bit 2 is 0.
- R7: Status bits are sticky. They stay set after their cause goes away and after their enable is cleared.
- R8: Writing 1 to enable bit 4 makes that bit read 1 for exactly one cycle and then 0. On the clock edge where it reads 1, both status bits clear, and this clear wins over any set that arrives on the same edge.
- R9: If a cause is still present and still enabled, the status bit sets again on the edge after the clear.
- R10: `alert_n` is 0 whenever a status bit is set and the override is not in effect. It is 1 when both status bits are 0.
- R11: When control bit 0 and enable bit 3 are both 1, `alert_n` is forced to 1. Control bit 0 alone has no effect.
- R12: `smp_ready` is 0 while reset is held and 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index (1 enable, 2 threshold, 3 control) |
| wr_data | input | 8 | Write data |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (high whenever out of reset) |
| smp_data | input | 12 | Current-channel sample |
| oc_active | input | 1 | Overcurrent condition present |
| tmr_expired | input | 1 | Overcurrent timer has expired |
| stat_adc | output | 1 | Sticky ADC over-threshold status |
| stat_oc | output | 1 | Sticky timed-overcurrent status |
| en_rb | output | 8 | Enable register readback |
| th_rb | output | 8 | Threshold register readback |
| ctl_rb | output | 8 | Control register readback |
| alert_n | output | 1 | Active-low alert pin |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, an 8-bit threshold and a run length of four. With a run length of four, the bench can walk a full run, break it, rebuild it and hold it at saturation with a few samples from a short vector table. The 8-bit threshold lets the bench probe both the full-scale value 0xFF and the case where the sample's upper byte equals the threshold. Directed cases then cover clear-versus-set precedence, re-setting after a clear and the gated software-off override.

// File: rtl/ocp_alert_pkg.sv
package ocp_alert_pkg;

  localparam int REG_IDX_W = 2;

  localparam logic [REG_IDX_W-1:0] IDX_EN  = 2'd1;
  localparam logic [REG_IDX_W-1:0] IDX_TH  = 2'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CTL = 2'd3;

  // enable register layout, bit 0 first from the right
  typedef struct packed {
    logic clr;      // bit 4, self-clearing
    logic off_en;   // bit 3
    logic oc_en;    // bit 2
    logic run_en;   // bit 1
    logic one_en;   // bit 0
  } en_t;

  localparam int EN_W = $bits(en_t);
  localparam en_t EN_RST = '{clr: 1'b0, off_en: 1'b0, oc_en: 1'b1,
                             run_en: 1'b0, one_en: 1'b0};

  localparam int SRC_ADC = 0;
  localparam int SRC_OC  = 1;
  localparam int NSRC    = 2;

endpackage

// File: rtl/ocp_alert_regs.sv
module ocp_alert_regs
  import ocp_alert_pkg::*;
#(
  parameter int TH_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  output en_t                  en_q,
  output logic [TH_W-1:0]      th_q,
  output logic                 swoff_q
);

  logic wr_en_reg, wr_th_reg, wr_ctl_reg;

  always_comb begin
    wr_en_reg  = wr_en && (wr_idx == IDX_EN);
    wr_th_reg  = wr_en && (wr_idx == IDX_TH);
    wr_ctl_reg = wr_en && (wr_idx == IDX_CTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= EN_RST;
      th_q    <= '1;
      swoff_q <= 1'b0;
    end else begin
      if (wr_en_reg)
        en_q <= en_t'(wr_data[EN_W-1:0]);
      else if (en_q.clr)
        en_q.clr <= 1'b0;
      if (wr_th_reg)
        th_q <= wr_data[TH_W-1:0];
      if (wr_ctl_reg)
        swoff_q <= wr_data[0];
    end
  end

endmodule

// File: rtl/ocp_exceed_track.sv
module ocp_exceed_track #(
  parameter int SMP_W   = 12,
  parameter int TH_W    = 8,
  parameter int RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SMP_W-1:0] sample,
  input  logic [TH_W-1:0]  th,
  output logic             over,
  output logic             run_full
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [TH_W-1:0]  top_bits;
  logic             unused_low;

  assign top_bits   = sample[SMP_W-1 -: TH_W];
  assign unused_low = ^sample[SMP_W-TH_W-1:0];

  always_comb begin
    over = top_bits > th;
    if (!over)
      cnt_nxt = '0;
    else if (cnt_q == CNT_MAX)
      cnt_nxt = cnt_q;
    else
      cnt_nxt = cnt_q + 1'b1;
    run_full = over && (cnt_nxt == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (fire)
      cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/ocp_status_core.sv
module ocp_status_core
  import ocp_alert_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSRC-1:0] set_vec,
  input  logic            swoff_eff,
  output logic [NSRC-1:0] stat_vec,
  output logic            alert_n
);

  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stat_vec[i] <= 1'b0;
      else if (clr)
        stat_vec[i] <= 1'b0;
      else if (set_vec[i])
        stat_vec[i] <= 1'b1;
    end
  end

  assign alert_n = ~(|stat_vec) | swoff_eff;

endmodule

// File: rtl/ocp_alert_ctrl.sv
module ocp_alert_ctrl
  import ocp_alert_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int TH_W    = 8,
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [SMP_W-1:0]     smp_data,
  input  logic                 oc_active,
  input  logic                 tmr_expired,
  output logic                 stat_adc,
  output logic                 stat_oc,
  output logic [DATA_W-1:0]    en_rb,
  output logic [TH_W-1:0]      th_rb,
  output logic [DATA_W-1:0]    ctl_rb,
  output logic                 alert_n
);

  en_t             en_q;
  logic [TH_W-1:0] th_q;
  logic            swoff_q;
  logic            fire, over, run_full;
  logic [NSRC-1:0] set_vec, stat_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_ready <= 1'b0;
    else        smp_ready <= 1'b1;
  end

  assign fire = smp_valid && smp_ready;

  ocp_alert_regs #(.TH_W(TH_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .en_q(en_q), .th_q(th_q), .swoff_q(swoff_q)
  );

  ocp_exceed_track #(.SMP_W(SMP_W), .TH_W(TH_W), .RUN_LEN(RUN_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sample(smp_data), .th(th_q),
    .over(over), .run_full(run_full)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_ADC] = fire && ((en_q.one_en && over) || (en_q.run_en && run_full));
    set_vec[SRC_OC]  = en_q.oc_en && oc_active && tmr_expired;
  end

  ocp_status_core u_stat (
    .clk(clk), .rst_n(rst_n), .clr(en_q.clr), .set_vec(set_vec),
    .swoff_eff(en_q.off_en && swoff_q), .stat_vec(stat_vec), .alert_n(alert_n)
  );

  assign stat_adc = stat_vec[SRC_ADC];
  assign stat_oc  = stat_vec[SRC_OC];
  assign en_rb    = DATA_W'(en_q);
  assign th_rb    = th_q;
  assign ctl_rb   = DATA_W'(swoff_q);

endmodule

// File: rtl/ocp_alert_chk.sv
module ocp_alert_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_idx,
  input logic              oc_active,
  input logic              tmr_expired,
  input logic              smp_ready,
  input logic              stat_adc,
  input logic              stat_oc,
  input logic [DATA_W-1:0] en_rb,
  input logic [DATA_W-1:0] ctl_rb,
  input logic              alert_n
);

  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rb[4] |=> (!stat_oc && !stat_adc));

  // R8
  clr_self_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rb[4] && !(wr_en && wr_idx == 2'd1)) |=> !en_rb[4]);

  // R6
  oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rb[2] && oc_active && tmr_expired && !en_rb[4]) |=> stat_oc);

  // R6
  oc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_oc) |-> $past(oc_active && tmr_expired));

  // R7
  oc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_oc && !en_rb[4]) |=> stat_oc);

  // R7
  adc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_adc && !en_rb[4]) |=> stat_adc);

  // R10
  idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_oc && !stat_adc) |-> alert_n);

  // R11
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rb[3] && ctl_rb[0]) |-> alert_n);

  // R12
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);

endmodule

bind ocp_alert_ctrl ocp_alert_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .oc_active(oc_active), .tmr_expired(tmr_expired), .smp_ready(smp_ready),
  .stat_adc(stat_adc), .stat_oc(stat_oc), .en_rb(en_rb), .ctl_rb(ctl_rb),
  .alert_n(alert_n)
);

// File: tb/ocp_alert_ctrl_test.sv
module ocp_alert_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_data = '0;
  logic        oc_active = 1'b0;
  logic        tmr_expired = 1'b0;
  logic        stat_adc, stat_oc, alert_n;
  logic [7:0]  en_rb, th_rb, ctl_rb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ocp_alert_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .oc_active(oc_active), .tmr_expired(tmr_expired), .stat_adc(stat_adc),
    .stat_oc(stat_oc), .en_rb(en_rb), .th_rb(th_rb), .ctl_rb(ctl_rb),
    .alert_n(alert_n)
  );

  // {valid, sample, expected stat_adc}; enable = run mode, threshold 0x80
  localparam logic [13:0] RUN_VEC [8] = '{
    {1'b1, 12'h810, 1'b0},
    {1'b1, 12'h900, 1'b0},
    {1'b0, 12'hFFF, 1'b0},
    {1'b1, 12'h80F, 1'b0},
    {1'b1, 12'h810, 1'b0},
    {1'b1, 12'h820, 1'b0},
    {1'b1, 12'h830, 1'b0},
    {1'b1, 12'hFFF, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic smp(input logic v, input logic [11:0] d);
    smp_valid = v; smp_data = d;
    step();
    smp_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R12 ready in reset", 16'(smp_ready), 16'h0);
    rst_n = 1'b1;
    step();
    chk("R1 enable rb", 16'(en_rb), 16'h04);
    chk("R1 threshold rb", 16'(th_rb), 16'hFF);
    chk("R1 control rb", 16'(ctl_rb), 16'h00);
    chk("R1 status", 16'({stat_oc, stat_adc}), 16'h0);
    chk("R1 alert_n", 16'(alert_n), 16'h1);
    chk("R12 ready after reset", 16'(smp_ready), 16'h1);

    // R2 register writes
    wr(2'd0, 8'hAA);
    chk("R2 idx0 enable", 16'(en_rb), 16'h04);
    chk("R2 idx0 threshold", 16'(th_rb), 16'hFF);
    chk("R2 idx0 control", 16'(ctl_rb), 16'h00);
    wr(2'd2, 8'h80);
    chk("R2 threshold write", 16'(th_rb), 16'h80);
    wr(2'd3, 8'hFE);
    chk("R2 control bit0 only", 16'(ctl_rb), 16'h00);
    wr(2'd1, 8'hEF);
    chk("R2 enable upper bits", 16'(en_rb), 16'h0F);
    wr(2'd1, 8'h02);
    chk("R2 enable write", 16'(en_rb), 16'h02);

    // R5 table walk
    for (int i = 0; i < 8; i++) begin
      smp(RUN_VEC[i][13], RUN_VEC[i][12:1]);
      chk("R5 run vector", 16'(stat_adc), 16'(RUN_VEC[i][0]));
    end

    // R8 clear, R5 saturation
    wr(2'd1, 8'h12);
    chk("R8 clear bit reads 1", 16'(en_rb), 16'h12);
    step();
    chk("R8 clear bit drops", 16'(en_rb), 16'h02);
    chk("R8 adc cleared", 16'(stat_adc), 16'h0);
    smp(1'b1, 12'hFFF);
    chk("R5 saturated run re-sets", 16'(stat_adc), 16'h1);

    // R3 / R4 single sample
    wr(2'd1, 8'h11);
    step();
    chk("R8 adc cleared again", 16'(stat_adc), 16'h0);
    wr(2'd2, 8'hFF);
    smp(1'b1, 12'hFFF);
    chk("R3 full scale never exceeds", 16'(stat_adc), 16'h0);
    wr(2'd2, 8'h10);
    smp(1'b1, 12'h10F);
    chk("R3 equal not exceed", 16'(stat_adc), 16'h0);
    smp(1'b0, 12'hFFF);
    chk("R4 invalid sample ignored", 16'(stat_adc), 16'h0);
    smp(1'b1, 12'h110);
    chk("R4 single exceed", 16'(stat_adc), 16'h1);
    chk("R10 alert low", 16'(alert_n), 16'h0);

    // R11 override
    wr(2'd3, 8'h01);
    chk("R11 swoff alone no effect", 16'(alert_n), 16'h0);
    wr(2'd1, 8'h09);
    chk("R11 override forces high", 16'(alert_n), 16'h1);
    chk("R7 adc sticky under override", 16'(stat_adc), 16'h1);
    wr(2'd3, 8'h00);
    chk("R10 alert low again", 16'(alert_n), 16'h0);

    // R6 overcurrent latch
    wr(2'd1, 8'h14);
    step();
    chk("R10 alert high when clear", 16'(alert_n), 16'h1);
    oc_active = 1'b1; tmr_expired = 1'b0;
    step();
    chk("R6 oc without timer", 16'(stat_oc), 16'h0);
    oc_active = 1'b0; tmr_expired = 1'b1;
    step();
    chk("R6 timer without oc", 16'(stat_oc), 16'h0);
    oc_active = 1'b1;
    step();
    chk("R6 oc latched", 16'(stat_oc), 16'h1);

    // R8 / R9 clear with cause present
    wr(2'd1, 8'h14);
    chk("R8 status before clear edge", 16'(stat_oc), 16'h1);
    step();
    chk("R8 clear wins over oc set", 16'(stat_oc), 16'h0);
    step();
    chk("R9 oc re-sets", 16'(stat_oc), 16'h1);

    // R7 sticky with cause and enable gone
    oc_active = 1'b0; tmr_expired = 1'b0;
    wr(2'd1, 8'h00);
    step();
    chk("R7 oc sticky", 16'(stat_oc), 16'h1);

    // R6 disabled
    wr(2'd1, 8'h10);
    oc_active = 1'b1; tmr_expired = 1'b1;
    step(); step();
    chk("R6 disabled no latch", 16'(stat_oc), 16'h0);
    oc_active = 1'b0; tmr_expired = 1'b0;

    // R8 clear wins over adc set on same edge
    wr(2'd1, 8'h11);
    smp(1'b1, 12'h200);
    chk("R8 clear wins over adc set", 16'(stat_adc), 16'h0);
    smp(1'b1, 12'h200);
    chk("R4 set after clear", 16'(stat_adc), 16'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule